// File: doc/BRIEF.md
# Four-Path Match Load Scheduler

This block feeds a fixed-latency content-addressable matcher from four per-path header queues. Each path offers a 256-bit search key as eight 32-bit beats. The scheduler drains two queues side by side while the other two wait, then drains the second pair. Every pair of beats taken in a cycle goes straight onto a 64-bit matcher write bus. The 1024-bit search word is therefore fully transferred by the end of the sixteenth load cycle, and the matcher start pulse goes out in that same cycle.

The matcher then returns four results one after another, one per path, each spaced twelve cycles apart. The scheduler reads no queue data while matching is in progress. It steers each result into the result FIFO of the path it belongs to. When a result FIFO is full, the result is held at the matcher and the round stretches until room appears. The next round begins in the cycle after the fourth result is accepted, provided all four queues hold a complete key. An unstalled round therefore takes 64 cycles.

A parameterised matcher stub with a small computed rule table is part of the project. It is connected to the scheduler's matcher ports at system level.

Top module: `match_load_sched`

## Requirements
- R1: While reset is asserted and in the first idle cycle after it (with no queue valid), all queue ready outputs, the write-bus valid, the start pulse and all result-FIFO write enables are low.
- R2: A round starts only in a cycle where all four queue valids are high. Until then no ready is raised. A source keeps its valid high until the eight beats of its key have been taken.
- R3: In load cycles 0 to 7 of a round, readies of paths 0 and 1 are high. In load cycles 8 to 15, readies of paths 2 and 3 are high. Exactly one beat is taken from each ready queue per cycle, and no other ready is ever high.
- R4: In every load cycle the write-bus valid is high and the bus carries the two beats just taken: the even path in bits 31:0 and the odd path in bits 63:32.
- R5: The matcher start pulse is high for exactly one cycle, the sixteenth load cycle, together with the last bus beat.
- R6: From the start pulse until the fourth result of the round is accepted, no queue ready is high.
- R7: The matcher stub rebuilds each path's key with beat t in key bits 32t+31:32t. It returns the lowest matching rule index. Rule 0 matches key byte 7:0 = 0x11 with key bit 255 set. Rule r (1 to 5) matches key byte 7:0 = 0x11·r. With no match it returns 0xF.
- R8: The matcher presents a result 12 cycles after the start pulse or after the previous result was accepted, and holds it with a steady code until it is accepted.
- R9: Results are accepted in path order 0, 1, 2, 3. Each raises the write enable of its own path only, in its acceptance cycle, with the matcher's code on the shared write data.
- R10: No write enable is raised into a full FIFO. The pending result waits, and the round grows by the number of stalled cycles.
- R11: With all queues supplied and no FIFO full, start pulses of consecutive rounds are exactly 64 cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| qValid | input | 4 | Per-path queue holds a complete key |
| qData | input | 128 | Per-path 32-bit beat, path p in bits 32p+31:32p |
| qReady | output | 4 | Per-path beat taken this cycle |
| mWrData | output | 64 | Matcher write bus, two beats |
| mWrValid | output | 1 | Matcher write bus carries a beat |
| mStart | output | 1 | Search word complete, begin matching |
| mResValid | input | 1 | Matcher presents a result |
| mResCode | input | 4 | Matched rule index or 0xF |
| mResReady | output | 1 | Result accepted this cycle |
| fWrEn | output | 4 | Per-path result FIFO write enable |
| fWrData | output | 4 | Result code written to the FIFO |
| fFull | input | 4 | Per-path result FIFO full |

## Verification
Queue readies and bus beats respond in the same cycle as the valids that launch a round. The start pulse is due 15 cycles after the first load cycle, and the first result write 12 cycles after that, with later writes 12 cycles after each acceptance. The bench keeps its own behavioural model of the queues, the round position and the twelve-cycle result timer. It compares every output against that model half a cycle after each clock edge, so each expected change is checked in the exact cycle it falls due. Round spacing is measured from the observed start pulses, both without stalls and across a 20-cycle stall on one FIFO.

// File: rtl/match_sched_pkg.sv
package match_sched_pkg;
  localparam int NUM_PATHS = 4;
  localparam int PATH_W    = $clog2(NUM_PATHS);

  // strobes from sequencing control to the steering datapath
  typedef struct packed {
    logic              loadEn;   // a load cycle: take beats, drive bus
    logic [PATH_W-1:0] grp;      // which path pair is being read
    logic              resWrite; // a result is accepted this cycle
    logic [PATH_W-1:0] resPath;  // path the accepted result belongs to
  } schedStrb_t;
endpackage

// File: rtl/match_stub.sv
module match_stub
  import match_sched_pkg::*;
#(
  parameter int Q_W       = 32,
  parameter int KEY_W     = 256,
  parameter int BUS_W     = 64,
  parameter int RES_W     = 4,
  parameter int NUM_RULES = 6,
  parameter int LAT       = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [BUS_W-1:0] wrData,
  input  logic             wrValid,
  input  logic             start,
  output logic             resValid,
  output logic [RES_W-1:0] resCode,
  input  logic             resReady
);
  localparam int LANES    = BUS_W / Q_W;
  localparam int BEATS    = KEY_W / Q_W;
  localparam int LOAD_CYC = NUM_PATHS * BEATS / LANES;
  localparam int BW       = $clog2(LOAD_CYC);
  localparam int LW       = $clog2(LAT);

  logic [KEY_W-1:0] keyMem [NUM_PATHS];
  logic [BW-1:0]    beatCnt;
  logic             busy;
  logic [LW-1:0]    tmr;
  logic [PATH_W-1:0] ridx;

  // rule r: compared value and care mask, computed rather than stored
  function automatic logic [KEY_W-1:0] ruleVal(input int r);
    logic [KEY_W-1:0] v;
    v      = '0;
    v[7:0] = 8'((r == 0) ? 17 : 17 * r);
    if (r == 0) v[KEY_W-1] = 1'b1;
    return v;
  endfunction

  function automatic logic [KEY_W-1:0] ruleCare(input int r);
    logic [KEY_W-1:0] c;
    c      = '0;
    c[7:0] = 8'hFF;
    if (r == 0) c[KEY_W-1] = 1'b1;
    return c;
  endfunction

  function automatic logic [RES_W-1:0] firstHit(input logic [KEY_W-1:0] k);
    logic [RES_W-1:0] code;
    code = '1;
    for (int r = NUM_RULES - 1; r >= 0; r--)
      if (((k ^ ruleVal(r)) & ruleCare(r)) == '0) code = RES_W'(r);
    return code;
  endfunction

  always_ff @(posedge clk) begin
    if (wrValid)
      for (int l = 0; l < LANES; l++)
        keyMem[(int'(beatCnt) / BEATS) * LANES + l][(int'(beatCnt) % BEATS) * Q_W +: Q_W]
          <= wrData[l*Q_W +: Q_W];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      beatCnt <= '0;
      busy    <= 1'b0;
      tmr     <= '0;
      ridx    <= '0;
    end else begin
      if (wrValid)
        beatCnt <= (beatCnt == BW'(LOAD_CYC - 1)) ? '0 : beatCnt + 1'b1;
      if (start) begin
        busy <= 1'b1;
        tmr  <= '0;
        ridx <= '0;
      end else if (busy) begin
        if (tmr != LW'(LAT - 1)) begin
          tmr <= tmr + 1'b1;
        end else if (resReady) begin
          tmr  <= '0;
          ridx <= ridx + 1'b1;
          if (ridx == PATH_W'(NUM_PATHS - 1)) busy <= 1'b0;
        end
      end
    end
  end

  assign resValid = busy && (tmr == LW'(LAT - 1));
  assign resCode  = firstHit(keyMem[ridx]);
endmodule

// File: rtl/sched_ctrl.sv
module sched_ctrl
  import match_sched_pkg::*;
#(
  parameter int Q_W   = 32,
  parameter int KEY_W = 256,
  parameter int BUS_W = 64
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_PATHS-1:0] qValid,
  input  logic                 mResValid,
  input  logic [NUM_PATHS-1:0] fFull,
  output schedStrb_t           strb,
  output logic                 mStart,
  output logic                 mResReady
);
  localparam int LANES    = BUS_W / Q_W;
  localparam int BEATS    = KEY_W / Q_W;
  localparam int LOAD_CYC = NUM_PATHS * BEATS / LANES;
  localparam int CW       = $clog2(LOAD_CYC);

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_MATCH} phase_t;

  phase_t            phase;
  logic [CW-1:0]     loadCnt;
  logic [CW-1:0]     beatNow;
  logic [PATH_W-1:0] resCnt;
  logic              allValid, loading, lastBeat, roomNow, accept;

  always_comb begin
    allValid = &qValid;
    loading  = (phase == S_LOAD) || ((phase == S_IDLE) && allValid);
    beatNow  = (phase == S_LOAD) ? loadCnt : '0;
    lastBeat = loading && (beatNow == CW'(LOAD_CYC - 1));
    roomNow  = !fFull[resCnt];
    accept   = (phase == S_MATCH) && mResValid && roomNow;

    strb.loadEn   = loading;
    strb.grp      = PATH_W'(int'(beatNow) / BEATS);
    strb.resWrite = accept;
    strb.resPath  = resCnt;

    mStart    = lastBeat;
    mResReady = (phase == S_MATCH) && roomNow;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase   <= S_IDLE;
      loadCnt <= '0;
      resCnt  <= '0;
    end else begin
      case (phase)
        S_IDLE: if (allValid) begin
          phase   <= S_LOAD;
          loadCnt <= CW'(1);
        end
        S_LOAD: if (lastBeat) begin
          phase   <= S_MATCH;
          loadCnt <= '0;
          resCnt  <= '0;
        end else begin
          loadCnt <= loadCnt + 1'b1;
        end
        S_MATCH: if (accept) begin
          resCnt <= resCnt + 1'b1;
          if (resCnt == PATH_W'(NUM_PATHS - 1)) phase <= S_IDLE;
        end
        default: phase <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sched_dp.sv
module sched_dp
  import match_sched_pkg::*;
#(
  parameter int Q_W   = 32,
  parameter int BUS_W = 64,
  parameter int RES_W = 4
) (
  input  schedStrb_t                 strb,
  input  logic [NUM_PATHS*Q_W-1:0]   qData,
  input  logic [RES_W-1:0]           mResCode,
  output logic [NUM_PATHS-1:0]       qReady,
  output logic [BUS_W-1:0]           mWrData,
  output logic                       mWrValid,
  output logic [NUM_PATHS-1:0]       fWrEn,
  output logic [RES_W-1:0]           fWrData
);
  localparam int LANES = BUS_W / Q_W;

  for (genvar p = 0; p < NUM_PATHS; p++) begin : g_path
    assign qReady[p] = strb.loadEn && (strb.grp == PATH_W'(p / LANES));
    assign fWrEn[p]  = strb.resWrite && (strb.resPath == PATH_W'(p));
  end

  always_comb begin
    mWrData = '0;
    if (strb.loadEn)
      for (int l = 0; l < LANES; l++)
        mWrData[l*Q_W +: Q_W] = qData[(int'(strb.grp) * LANES + l) * Q_W +: Q_W];
  end

  assign mWrValid = strb.loadEn;
  assign fWrData  = mResCode;
endmodule

// File: rtl/match_load_sched.sv
module match_load_sched
  import match_sched_pkg::*;
#(
  parameter int Q_W   = 32,
  parameter int KEY_W = 256,
  parameter int BUS_W = 64,
  parameter int RES_W = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NUM_PATHS-1:0]     qValid,
  input  logic [NUM_PATHS*Q_W-1:0] qData,
  output logic [NUM_PATHS-1:0]     qReady,
  output logic [BUS_W-1:0]         mWrData,
  output logic                     mWrValid,
  output logic                     mStart,
  input  logic                     mResValid,
  input  logic [RES_W-1:0]         mResCode,
  output logic                     mResReady,
  output logic [NUM_PATHS-1:0]     fWrEn,
  output logic [RES_W-1:0]         fWrData,
  input  logic [NUM_PATHS-1:0]     fFull
);
  schedStrb_t strb;

  sched_ctrl #(.Q_W(Q_W), .KEY_W(KEY_W), .BUS_W(BUS_W)) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .qValid    (qValid),
    .mResValid (mResValid),
    .fFull     (fFull),
    .strb      (strb),
    .mStart    (mStart),
    .mResReady (mResReady)
  );

  sched_dp #(.Q_W(Q_W), .BUS_W(BUS_W), .RES_W(RES_W)) dp_i (
    .strb     (strb),
    .qData    (qData),
    .mResCode (mResCode),
    .qReady   (qReady),
    .mWrData  (mWrData),
    .mWrValid (mWrValid),
    .fWrEn    (fWrEn),
    .fWrData  (fWrData)
  );
endmodule

// File: rtl/sched_chk.sv
module sched_chk
  import match_sched_pkg::*;
#(
  parameter int Q_W   = 32,
  parameter int KEY_W = 256,
  parameter int BUS_W = 64,
  parameter int RES_W = 4
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [NUM_PATHS-1:0] qValid,
  input logic [NUM_PATHS-1:0] qReady,
  input logic                 mWrValid,
  input logic                 mStart,
  input logic                 mResValid,
  input logic                 mResReady,
  input logic [RES_W-1:0]     mResCode,
  input logic [NUM_PATHS-1:0] fWrEn,
  input logic [NUM_PATHS-1:0] fFull
);
  localparam int LANES    = BUS_W / Q_W;
  localparam int BEATS    = KEY_W / Q_W;
  localparam int LOAD_CYC = NUM_PATHS * BEATS / LANES;

  logic [7:0] loadRun;  // consecutive bus beats seen so far

  always_ff @(posedge clk) begin
    if (!rstN)         loadRun <= '0;
    else if (mWrValid) loadRun <= loadRun + 1'b1;
    else               loadRun <= '0;
  end

  p_round_gate_r2: assert property (@(posedge clk) disable iff (!rstN)
    ((|qReady) && !$past(|qReady)) |-> (&qValid));

  p_pair_order_r3: assert property (@(posedge clk) disable iff (!rstN)
    (qReady[0] == qReady[1]) && (qReady[2] == qReady[3]) && !(qReady[0] && qReady[2]));

  p_start_len_r5: assert property (@(posedge clk) disable iff (!rstN)
    mStart |-> (mWrValid && (loadRun == 8'(LOAD_CYC - 1))));

  p_no_read_match_r6: assert property (@(posedge clk) disable iff (!rstN)
    mResValid |-> (qReady == '0));

  p_hold_result_r8: assert property (@(posedge clk) disable iff (!rstN)
    (mResValid && !mResReady) |=> (mResValid && $stable(mResCode)));

  p_one_write_r9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(fWrEn));

  p_write_has_result_r9: assert property (@(posedge clk) disable iff (!rstN)
    (|fWrEn) |-> (mResValid && mResReady));

  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rstN)
    (fWrEn & fFull) == '0);
endmodule

bind match_load_sched sched_chk #(.Q_W(Q_W), .KEY_W(KEY_W), .BUS_W(BUS_W), .RES_W(RES_W)) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .qValid    (qValid),
  .qReady    (qReady),
  .mWrValid  (mWrValid),
  .mStart    (mStart),
  .mResValid (mResValid),
  .mResReady (mResReady),
  .mResCode  (mResCode),
  .fWrEn     (fWrEn),
  .fFull     (fFull)
);

// File: tb/match_load_sched_tb_top.sv
`timescale 1ns/1ps
module match_load_sched_tb_top;
  logic         clk = 1'b0;
  logic         rstN;
  logic [3:0]   qValid;
  logic [127:0] qData;
  logic [3:0]   qReady;
  logic [63:0]  mWrData;
  logic         mWrValid, mStart, mResValid, mResReady;
  logic [3:0]   mResCode;
  logic [3:0]   fWrEn;
  logic [3:0]   fWrData;
  logic [3:0]   fFull;

  always #10 clk = ~clk;

  match_load_sched dut_i (
    .clk(clk), .rstN(rstN), .qValid(qValid), .qData(qData), .qReady(qReady),
    .mWrData(mWrData), .mWrValid(mWrValid), .mStart(mStart),
    .mResValid(mResValid), .mResCode(mResCode), .mResReady(mResReady),
    .fWrEn(fWrEn), .fWrData(fWrData), .fFull(fFull)
  );

  match_stub stub_i (
    .clk(clk), .rstN(rstN), .wrData(mWrData), .wrValid(mWrValid), .start(mStart),
    .resValid(mResValid), .resCode(mResCode), .resReady(mResReady)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // bench-side queues
  logic [31:0] qMem [4][64];
  int qWr [4], qRd [4], qBase [4];
  bit cons [4];

  // behavioural model state
  int mMode;          // 0 idle, 1 load, 2 match
  int mBeat, mTmr, mRidx;
  logic [7:0] mLow [4];
  logic       mMsb [4];
  int resSeen [4];
  int startAt [8];
  int nStart = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [3:0] refCode(input logic [7:0] low, input logic msb);
    if (low == 8'h11 && msb) return 4'd0;
    case (low)
      8'h11: return 4'd1;
      8'h22: return 4'd2;
      8'h33: return 4'd3;
      8'h44: return 4'd4;
      8'h55: return 4'd5;
      default: return 4'hF;
    endcase
  endfunction

  task automatic pushPortion(input int p, input logic [7:0] low, input logic msb, input logic [7:0] tag);
    for (int t = 0; t < 8; t++) begin
      logic [31:0] w;
      w = {tag, 8'(t), 8'(p), 8'hA0 | 8'(t)};
      if (t == 0) w[7:0] = low;
      if (t == 7) w[31]  = msb;
      qMem[p][qWr[p] % 64] = w;
      qWr[p]++;
    end
  endtask

  task automatic pushRound(input int r, input int p);
    logic [7:0] lows [7];
    int idx;
    lows = '{8'h11, 8'h11, 8'h22, 8'h33, 8'h55, 8'h66, 8'h05};
    idx = (r * 4 + p) % 7;
    pushPortion(p, lows[idx], (idx == 0), 8'(r * 16 + p));
  endtask

  task automatic drive();
    for (int p = 0; p < 4; p++) begin
      qValid[p] = (qWr[p] - qBase[p]) >= 8;
      qData[p*32 +: 32] = qMem[p][qRd[p] % 64];
    end
  endtask

  task automatic step(input int cyc);
    bit allV, loadNow, resV;
    int b, g;
    logic [3:0]  expReady, expWr;
    logic [63:0] expData;
    logic        expStart;
    logic [3:0]  expCode;
    string       rtag, wtag;

    allV    = &qValid;
    loadNow = (mMode == 1) || (mMode == 0 && allV);
    b       = (mMode == 1) ? mBeat : 0;
    g       = b / 8;
    expReady = loadNow ? ((g == 0) ? 4'b0011 : 4'b1100) : 4'b0000;
    expData  = {qMem[g*2+1][qRd[g*2+1] % 64], qMem[g*2][qRd[g*2] % 64]};
    expStart = loadNow && (b == 15);
    resV     = (mMode == 2) && (mTmr == 11);
    expWr    = (resV && !fFull[mRidx]) ? 4'(1 << mRidx) : 4'b0000;
    expCode  = refCode(mLow[mRidx % 4], mMsb[mRidx % 4]);

    rtag = (mMode == 2) ? "R6" : ((mMode == 0 && !allV) ? "R2" : "R3");
    check(qReady == expReady, rtag, "qReady", 64'(qReady), 64'(expReady));
    check(mWrValid == loadNow, "R4", "mWrValid", 64'(mWrValid), 64'(loadNow));
    if (loadNow) check(mWrData == expData, "R4", "mWrData", mWrData, expData);
    check(mStart == expStart, "R5", "mStart", 64'(mStart), 64'(expStart));
    wtag = (expWr != 0) ? "R9" : ((resV) ? "R10" : "R8");
    check(fWrEn == expWr, wtag, "fWrEn", 64'(fWrEn), 64'(expWr));
    if (expWr != 0) check(fWrData == expCode, "R7", "fWrData", 64'(fWrData), 64'(expCode));

    // observations for round-level checks
    if (mStart && nStart < 8) begin startAt[nStart] = cyc; nStart++; end
    for (int p = 0; p < 4; p++) if (fWrEn[p]) resSeen[p]++;

    if (cyc == 30) check(qReady == 4'b0000 && !mWrValid, "R2",
                         "ready with three queues filled", 64'(qReady), 64'h0);

    // advance model to the next cycle
    if (loadNow) begin
      for (int l = 0; l < 2; l++) begin
        int p;
        logic [31:0] d;
        p = g * 2 + l;
        d = qMem[p][qRd[p] % 64];
        if (b % 8 == 0) mLow[p] = d[7:0];
        if (b % 8 == 7) mMsb[p] = d[31];
        cons[p] = 1'b1;
      end
      if (b == 15) begin mMode = 2; mTmr = 0; mRidx = 0; end
      else begin mMode = 1; mBeat = b + 1; end
    end else if (mMode == 2) begin
      if (mTmr < 11) mTmr++;
      else if (!fFull[mRidx]) begin
        if (mRidx == 3) mMode = 0;
        else begin mRidx++; mTmr = 0; end
      end
    end
  endtask

  initial begin
    rstN = 1'b0; fFull = '0; qValid = '0; qData = '0;
    mMode = 0; mBeat = 0; mTmr = 0; mRidx = 0;
    for (int p = 0; p < 4; p++) begin
      qWr[p] = 0; qRd[p] = 0; qBase[p] = 0; cons[p] = 1'b0;
      mLow[p] = '0; mMsb[p] = 1'b0; resSeen[p] = 0;
      for (int i = 0; i < 64; i++) qMem[p][i] = '0;
    end
    for (int i = 0; i < 8; i++) startAt[i] = 0;

    for (int cyc = 0; cyc < 340; cyc++) begin
      @(posedge clk);
      #1;
      for (int p = 0; p < 4; p++) if (cons[p]) begin
        qRd[p]++;
        if (qRd[p] - qBase[p] == 8) qBase[p] += 8;
        cons[p] = 1'b0;
      end
      if (cyc == 5) rstN = 1'b1;
      if (cyc == 8) for (int p = 0; p < 3; p++) pushRound(0, p);
      if (cyc == 31) begin
        pushRound(0, 3);
        for (int r = 1; r < 4; r++) for (int p = 0; p < 4; p++) pushRound(r, p);
      end
      if (cyc == 180) fFull[2] = 1'b1;
      if (cyc == 230) fFull[2] = 1'b0;
      drive();
      @(negedge clk);
      if (!rstN) begin
        if (cyc == 2) begin
          check(qReady == 4'b0, "R1", "qReady in reset", 64'(qReady), 64'h0);
          check(!mWrValid && !mStart, "R1", "bus valid/start in reset",
                64'({mWrValid, mStart}), 64'h0);
          check(fWrEn == 4'b0, "R1", "fWrEn in reset", 64'(fWrEn), 64'h0);
        end
      end else begin
        if (cyc == 5) check(qReady == 4'b0 && fWrEn == 4'b0 && !mStart, "R1",
                            "idle after reset", 64'({qReady, fWrEn}), 64'h0);
        step(cyc);
      end
    end

    check(nStart == 4, "R11", "rounds started", 64'(nStart), 64'd4);
    check(startAt[1] - startAt[0] == 64, "R11", "round 1 to 2 spacing",
          64'(startAt[1] - startAt[0]), 64'd64);
    check(startAt[2] - startAt[1] == 64, "R11", "round 2 to 3 spacing",
          64'(startAt[2] - startAt[1]), 64'd64);
    check(startAt[3] - startAt[2] == 84, "R10", "stalled round spacing",
          64'(startAt[3] - startAt[2]), 64'd84);
    for (int p = 0; p < 4; p++)
      check(resSeen[p] == 4, "R9", $sformatf("results into path %0d", p),
            64'(resSeen[p]), 64'd4);

    $display("%0d/%0d checks passed", checks - fails, checks);
    done = 1'b1;
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog run did not finish actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule